// File: doc/BRIEF.md
# Dual-Halfword Saturation Unit

This block clamps two packed 16-bit signed values to a programmable bit width. The 32-bit source word is treated as a low lane (bits 15:0) and a high lane (bits 31:16). Both lanes are clamped in parallel, and the two clamped values are packed back into a 32-bit result in the same lane positions. A mode bit selects between two ranges. The signed range is symmetric about zero. The unsigned range starts at zero, and its input is still read as signed, so a negative lane is clamped to zero.

If either lane had to be clamped, a sticky saturation flag is set. Only an explicit clear or reset brings the flag back to zero. The result register and the flag change only when an operation strobe and a condition-pass input are both high. This lets a pipeline squash an operation whose condition failed.

Top module: `dual_lane_sat`

## Requirements
- R1: Each lane is read as a 16-bit two's-complement value and is clamped independently of the other lane. The low lane is source bits 15:0 and the high lane is source bits 31:16.
- R2: The low-lane result is placed in result bits 15:0 and the high-lane result in result bits 31:16. A value that is already inside the range passes through unchanged.
- R3: With `mode_uns`=0 (signed), the width is `sat_imm`+1 (1 to 16 bits). Each lane is clamped to the range from -2^`sat_imm` to 2^`sat_imm`-1, and a lane overflows when its value lies outside that range.
- R4: With `mode_uns`=1 (unsigned), the width is `sat_imm` (0 to 15 bits). Each lane is clamped to the range from 0 to 2^`sat_imm`-1. A negative lane gives 0 and counts as an overflow. Result bits 15 and 31 are therefore always 0 in this mode.
- R5: With `mode_uns`=1 and `sat_imm`=0, both result lanes are 0. Any nonzero lane counts as an overflow.
- R6: When an overflow occurs in either lane of an accepted operation, `q_flag` goes to 1 on the same clock edge that loads the result. An operation without overflow leaves the flag unchanged.
- R7: An operation is accepted only on a rising edge where `in_valid` and `cond_pass` are both 1. On any other edge, `result` holds its value and `q_flag` is not set.
- R8: `q_clear`=1 drives `q_flag` to 0 on the next edge. This takes priority over a set in the same cycle.
- R9: A synchronous active-high `rst` drives `result` and `q_flag` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| cond_pass | input | 1 | Condition-pass qualifier for the operation |
| mode_uns | input | 1 | 0 = signed clamp, 1 = unsigned clamp |
| sat_imm | input | 4 | Width immediate |
| src_word | input | 32 | Packed pair of signed halfwords |
| q_clear | input | 1 | Clears the sticky flag |
| result | output | 32 | Registered packed clamped halfwords |
| q_flag | output | 1 | Sticky saturation flag |

## Verification
The assertions assume that all inputs are known values at each rising edge once reset has been released. They also assume that reset is applied for at least one edge before any property is evaluated. The stimulus meets both assumptions. It drives every input only on falling edges, from one task, with defined values at all times. It holds reset across several edges at the start. The sweep covers every immediate in both modes, with each lane taking the values 0x8000, 0x7FFF, 0x0000 and 0xFFFF. Seeded random words with random strobe, condition and clear bits are added to reach the gating and clear-priority paths.

// File: rtl/dls_pkg.sv
package dls_pkg;
  localparam int unsigned LANE_W = 16;
  localparam int unsigned LANES  = 2;
  localparam int unsigned IMM_W  = 4;
  localparam int unsigned WORD_W = LANE_W * LANES;

  typedef enum logic {
    SAT_SIGNED   = 1'b0,
    SAT_UNSIGNED = 1'b1
  } sat_mode_e;
endpackage

// File: rtl/sat_lane_clamp.sv
module sat_lane_clamp #(
  parameter int unsigned LANE_W = 16,
  parameter int unsigned IMM_W  = 4
) (
  input  logic [LANE_W-1:0] lane_in,
  input  dls_pkg::sat_mode_e mode,
  input  logic [IMM_W-1:0]  imm,
  output logic [LANE_W-1:0] lane_out,
  output logic              lane_ovf
);
  // The upper limit 2^imm - 1 is the same in both modes. Only the lower
  // limit changes: -2^imm, written as ~upper, in signed mode, and 0 in
  // unsigned mode. With 2^IMM_W == LANE_W every limit fits a signed lane.
  logic [LANE_W-1:0] upper_pat;
  logic [LANE_W-1:0] lower_pat;
  logic              above;
  logic              below;

  always_comb begin
    upper_pat = ~({LANE_W{1'b1}} << imm);
    lower_pat = (mode == dls_pkg::SAT_UNSIGNED) ? '0 : ~upper_pat;
    above     = $signed(lane_in) > $signed(upper_pat);
    below     = $signed(lane_in) < $signed(lower_pat);
    if (above)      lane_out = upper_pat;
    else if (below) lane_out = lower_pat;
    else            lane_out = lane_in;
    lane_ovf = above | below;
  end
endmodule

// File: rtl/sat_sticky_flag.sv
module sat_sticky_flag (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic set,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)        flag <= 1'b0;
    else if (clear) flag <= 1'b0;
    else if (set)   flag <= 1'b1;
  end
endmodule

// File: rtl/dual_lane_sat.sv
module dual_lane_sat
  import dls_pkg::*;
#(
  parameter int unsigned P_LANE_W = dls_pkg::LANE_W,
  parameter int unsigned P_LANES  = dls_pkg::LANES,
  parameter int unsigned P_IMM_W  = dls_pkg::IMM_W,
  localparam int unsigned P_WORD_W = P_LANE_W * P_LANES
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic                cond_pass,
  input  logic                mode_uns,
  input  logic [P_IMM_W-1:0]  sat_imm,
  input  logic [P_WORD_W-1:0] src_word,
  input  logic                q_clear,
  output logic [P_WORD_W-1:0] result,
  output logic                q_flag
);
  sat_mode_e           mode;
  logic [P_WORD_W-1:0] packed_next;
  logic [P_LANES-1:0]  lane_ovf;
  logic                fire;

  assign mode = sat_mode_e'(mode_uns);
  assign fire = in_valid & cond_pass;

  for (genvar g = 0; g < P_LANES; g++) begin : g_lane
    sat_lane_clamp #(
      .LANE_W (P_LANE_W),
      .IMM_W  (P_IMM_W)
    ) u_clamp (
      .lane_in  (src_word[g*P_LANE_W +: P_LANE_W]),
      .mode     (mode),
      .imm      (sat_imm),
      .lane_out (packed_next[g*P_LANE_W +: P_LANE_W]),
      .lane_ovf (lane_ovf[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)       result <= '0;
    else if (fire) result <= packed_next;
  end

  sat_sticky_flag u_q (
    .clk   (clk),
    .rst   (rst),
    .clear (q_clear),
    .set   (fire & (|lane_ovf)),
    .flag  (q_flag)
  );
endmodule

// File: rtl/dls_checker.sv
module dls_checker #(
  parameter int unsigned LW = dls_pkg::LANE_W
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          cond_pass,
  input logic          mode_uns,
  input logic [3:0]    sat_imm,
  input logic          q_clear,
  input logic [2*LW-1:0] result,
  input logic          q_flag
);
  p_uns_nonneg_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cond_pass && mode_uns) |=> (!result[LW-1] && !result[2*LW-1]));

  p_uns_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cond_pass && mode_uns && sat_imm == 4'd0) |=> (result == '0));

  p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (q_flag && !q_clear) |=> q_flag);

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && cond_pass) |=> $stable(result));

  p_no_set_r7: assert property (@(posedge clk) disable iff (rst)
    (!(in_valid && cond_pass) && !q_clear) |=> $stable(q_flag));

  p_clear_r8: assert property (@(posedge clk) disable iff (rst)
    q_clear |=> !q_flag);
endmodule

bind dual_lane_sat dls_checker u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .cond_pass(cond_pass),
  .mode_uns(mode_uns), .sat_imm(sat_imm), .q_clear(q_clear),
  .result(result), .q_flag(q_flag)
);

// File: tb/tb_dual_lane_sat.sv
`timescale 1ns/1ps
module tb_dual_lane_sat;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid, cond_pass, mode_uns, q_clear;
  logic [3:0]  sat_imm;
  logic [31:0] src_word;
  logic [31:0] result;
  logic        q_flag;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_res;
  logic        exp_q;
  logic [15:0] corners [4];

  always #2.5 clk = ~clk;

  dual_lane_sat dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .cond_pass(cond_pass),
    .mode_uns(mode_uns), .sat_imm(sat_imm), .src_word(src_word),
    .q_clear(q_clear), .result(result), .q_flag(q_flag)
  );

  // Reference clamp: returns {overflow, lane}
  function automatic logic [16:0] ref_lane(input logic [15:0] v, input logic uns, input int imm);
    int x, hi, lo;
    x  = int'($signed(v));
    hi = (1 << imm) - 1;
    lo = uns ? 0 : -(1 << imm);
    if (x > hi)      return {1'b1, 16'(hi)};
    else if (x < lo) return {1'b1, 16'(lo)};
    else             return {1'b0, v};
  endfunction

  task automatic check(input string req, input logic [31:0] a_res, input logic a_q);
    checks++;
    if (a_res !== exp_res || a_q !== exp_q) begin
      errors++;
      $display("FAIL %s: result=%h q=%b expected result=%h q=%b",
               req, a_res, a_q, exp_res, exp_q);
    end
  endtask

  // Entered at a falling edge; drives, passes one rising edge, checks at next falling edge.
  task automatic op(input string req, input logic v, input logic cp, input logic u,
                    input logic [3:0] imm, input logic [31:0] src, input logic clr);
    logic [16:0] lo_r, hi_r;
    in_valid = v; cond_pass = cp; mode_uns = u; sat_imm = imm; src_word = src; q_clear = clr;
    lo_r = ref_lane(src[15:0], u, int'(imm));
    hi_r = ref_lane(src[31:16], u, int'(imm));
    if (v && cp) exp_res = {hi_r[15:0], lo_r[15:0]};
    if (clr) exp_q = 1'b0;
    else if (v && cp && (lo_r[16] || hi_r[16])) exp_q = 1'b1;
    @(negedge clk);
    check(req, result, q_flag);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd1234));
    corners[0] = 16'h8000; corners[1] = 16'h7FFF; corners[2] = 16'h0000; corners[3] = 16'hFFFF;
    rst = 1'b1; in_valid = 0; cond_pass = 0; mode_uns = 0; sat_imm = 0; src_word = 0; q_clear = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    exp_res = '0; exp_q = 1'b0;
    check("R9", result, q_flag);

    // R2: full-width signed pass-through
    op("R2", 1, 1, 0, 4'd15, 32'h8000_7FFF, 0);
    // R1: lanes clamped independently (low negative, high in range)
    op("R1", 1, 1, 0, 4'd7, 32'h0001_FF00, 0);
    op("R1", 1, 1, 0, 4'd7, 32'h7000_0005, 0);
    op("R8", 0, 0, 0, 4'd0, 32'h0, 1);
    // R4: negative lane in unsigned mode
    op("R4", 1, 1, 1, 4'd8, 32'h0010_FFFE, 0);
    // R7: strobe without cond_pass, cond_pass without strobe
    op("R8", 0, 0, 0, 4'd0, 32'h0, 1);
    op("R7", 1, 0, 0, 4'd0, 32'h7FFF_8000, 0);
    op("R7", 0, 1, 0, 4'd0, 32'h7FFF_8000, 0);
    // R6: set then hold
    op("R6", 1, 1, 0, 4'd0, 32'h0000_0005, 0);
    op("R6", 1, 1, 0, 4'd15, 32'h1234_5678, 0);
    // R8: clear beats overflow set
    op("R8", 1, 1, 0, 4'd0, 32'h7FFF_7FFF, 1);
    // R5: unsigned width 0
    op("R5", 1, 1, 1, 4'd0, 32'h0001_0000, 0);
    op("R5", 1, 1, 1, 4'd0, 32'h0000_0000, 1);

    // Sweep all immediates, both modes, corner lane pairs
    for (int m = 0; m < 2; m++) begin
      for (int i = 0; i < 16; i++) begin
        for (int a = 0; a < 4; a++) begin
          for (int b = 0; b < 4; b++) begin
            string tag;
            tag = (m == 0) ? "R3" : ((i == 0) ? "R5" : "R4");
            op(tag, 1, 1, m[0], 4'(i), {corners[b], corners[a]}, (a == 0 && b == 0));
          end
        end
      end
    end

    // Random mix
    for (int n = 0; n < 600; n++) begin
      logic [31:0] r;
      r = $urandom();
      op("R6", r[0] | r[1], r[2] | r[3], r[4], 4'(r[11:8]), $urandom(), (r[15:12] == 4'd0));
    end

    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    exp_res = '0; exp_q = 1'b0;
    check("R9", result, q_flag);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule